// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware activity for software profiling. It has one 32-bit cycle counter and a small bank of 32-bit event counters. Each event counter watches one line of an event input vector, and an 8-bit event code held per counter picks that line. Every clock cycle in which the chosen line is high and the counter is enabled adds one to the count. A single register port carries all control: a control word, separate set and clear registers for the counter enables and for the interrupt enables, an overflow status register, a counter selector, and two indirect windows through which software reads and writes the value and the event code of the selected counter.

When a counter wraps from all ones to zero, it raises its own overflow flag. One shared interrupt line is high while any flag is set and that counter's interrupt enable is also set. The cycle counter can run at full rate or advance once every 64 counted cycles. While a debug-inhibit input is high, the cycle counter can be held.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter, enable, interrupt enable, overflow flag, event code and the selector are zero, `irq` is low, and the control register (address 0x0) reads back 0x2000 for four counters: the implemented event-counter count sits in bits 15:11.
- R2: In the control register, bit 0 is the global enable, bit 3 the divide-by-64 mode, bit 4 the export enable and bit 5 the debug stop. Only these four bits are stored. Bits 1 and 2 and every other bit outside 15:11 always read 0, so writing all ones reads back 0x2039.
- R3: A counter advances by one on a clock edge only while control bit 0 and its own enable bit are both set. Bit 31 of the enable, interrupt-enable and overflow registers belongs to the cycle counter, and bit n belongs to event counter n.
- R4: Writing to the enable set register (0x1) sets each enable whose data bit is 1. Writing to the enable clear register (0x2) clears each enable whose data bit is 1. Data bits at 0 leave the enable unchanged. The interrupt enables work the same way through 0x3 (set) and 0x4 (clear). Reads of either address of a pair return the current mask, and unimplemented bits read 0.
- R5: An event counter whose code is below the number of event lines counts the cycles in which `evt_in[code]` is high. Any other code counts nothing. Only the low 8 bits of a code write are kept.
- R6: The selector (0x6, 5 bits kept) chooses the event counter that the value window (0x8) and the code window (0x9) reach. If the selector names no implemented counter, both windows read 0 and writes to them are ignored.
- R7: The cycle counter is read and written directly at 0x7. A write to any counter value takes priority over an increment on the same edge.
- R8: Writing 1 to control bit 1 clears all event counters, and writing 1 to control bit 2 clears the cycle counter and its divide phase. Each acts on the edge of that write, and neither bit is stored.
- R9: With bit 3 set, the cycle counter advances once every 64 counted cycles. After a cycle-counter clear, the first step comes on the 64th counted edge.
- R10: With bit 5 set, the cycle counter holds while `dbg_inhibit` is high. Event counters are not affected by `dbg_inhibit`.
- R11: A wrap from all ones to zero sets that counter's overflow flag. The status register (0x5) reads the flags. Writing ones to it clears the matching flags, and zero bits leave flags unchanged. If a flag is set and cleared on the same edge, it ends up set.
- R12: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set.
- R13: The `export_en` output follows control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | NUM_EVT | Event lines, level sampled every clock |
| dbg_inhibit | input | 1 | Debug-inhibit condition |
| irq | output | 1 | Combined overflow interrupt |
| export_en | output | 1 | Export enable from the control register |

## Verification
The bench aims at a counter loaded with all ones on the same edge an increment arrives. A design that lets the increment win would read back zero and set a false flag. It checks the wrap into the overflow flag and the write-one-to-clear rule with a mix of zero and one bits, where a design clearing on any write would drop flags it was told to keep. It counts exactly 63 and 64 edges after a clear in divide-by-64 mode, to catch an off-by-one prescaler. It also drives selector values past the last counter and event codes past the last line, where a design that wraps the index would corrupt or count a real counter. Random rounds cross random event codes, enable masks and event patterns against a cycle-by-cycle model.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   typedef enum logic [3:0] {
      A_CTRL   = 4'h0,
      A_EN_SET = 4'h1,
      A_EN_CLR = 4'h2,
      A_IE_SET = 4'h3,
      A_IE_CLR = 4'h4,
      A_OVF    = 4'h5,
      A_SEL    = 4'h6,
      A_CYC    = 4'h7,
      A_VAL    = 4'h8,
      A_TYPE   = 4'h9
   } pmu_addr_e;

   localparam int CYC_BIT   = 31;
   localparam int SEL_W     = 5;
   localparam int CODE_W    = 8;
   localparam int NUMF_LSB  = 11;
endpackage

// File: rtl/pmu_counter.sv
// Loadable up-counter: clear beats load, load beats increment.
module pmu_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   assign wrap = inc && !clr && !ld && (&cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (ld)   cnt <= ld_val;
      else if (inc)  cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/pmu_evt_mux.sv
// Selects one event line by code; codes past the last line give 0.
module pmu_evt_mux #(
   parameter int NUM_EVT = 8,
   parameter int CODE_W  = 8
) (
   input  logic [CODE_W-1:0]  code,
   input  logic [NUM_EVT-1:0] evt_in,
   output logic               hit
);
   always_comb begin
      hit = 1'b0;
      for (int j = 0; j < NUM_EVT; j++)
         if (code == CODE_W'(j)) hit = evt_in[j];
   end
endmodule

// File: rtl/pmu_prescaler.sv
// Cycle-counter step generator: full rate or one step per 2**DIV_LOG2 active cycles.
module pmu_prescaler #(
   parameter int DIV_LOG2 = 6,
   parameter bit HAS_DIV  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic active,
   input  logic div_mode,
   output logic tick
);
   if (HAS_DIV) begin : g_div
      logic [DIV_LOG2-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase_q <= '0;
         else if (clr)     phase_q <= '0;
         else if (active)  phase_q <= phase_q + DIV_LOG2'(1);
      end
      assign tick = active && !clr && (!div_mode || (&phase_q));
   end else begin : g_nodiv
      logic unused_div;
      assign unused_div = ^{div_mode, clk, rst_n};
      assign tick = active && !clr;
   end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
   import pmu_pkg::*;
#(
   parameter int NUM_CTR  = 4,
   parameter int NUM_EVT  = 8,
   parameter int CNT_W    = 32,
   parameter int DIV_LOG2 = 6,
   parameter bit HAS_DIV  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [3:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               dbg_inhibit,
   output logic               irq,
   output logic               export_en
);
   localparam logic [31:0] EVT_MASK  = (32'h1 << NUM_CTR) - 32'h1;
   localparam logic [31:0] IMPL_MASK = (32'h1 << CYC_BIT) | EVT_MASK;

   if (NUM_CTR < 1 || NUM_CTR > 31) begin : g_bad_ctr
      $error("NUM_CTR must lie in 1..31");
   end
   if (NUM_EVT < 1 || NUM_EVT > (1 << CODE_W)) begin : g_bad_evt
      $error("NUM_EVT must lie in 1..256");
   end
   if (CNT_W < 8 || CNT_W > 32) begin : g_bad_w
      $error("CNT_W must lie in 8..32");
   end
   if (DIV_LOG2 < 1 || DIV_LOG2 > 16) begin : g_bad_div
      $error("DIV_LOG2 must lie in 1..16");
   end

   logic              ctrl_en_q, ctrl_div_q, ctrl_exp_q, ctrl_dbg_q;
   logic [31:0]       en_q, ie_q, ovf_q, wrap_v;
   logic [SEL_W-1:0]  sel_q;
   logic [CNT_W-1:0]  cyc_cnt;
   logic [CNT_W-1:0]  evt_cnt  [NUM_CTR];
   logic [CODE_W-1:0] evt_type [NUM_CTR];
   logic              cyc_tick, cyc_run, cyc_rst, evt_rst, sel_ok;

   wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
   wire wr_enst = reg_wr && (reg_addr == A_EN_SET);
   wire wr_encl = reg_wr && (reg_addr == A_EN_CLR);
   wire wr_iest = reg_wr && (reg_addr == A_IE_SET);
   wire wr_iecl = reg_wr && (reg_addr == A_IE_CLR);
   wire wr_ovf  = reg_wr && (reg_addr == A_OVF);
   wire wr_sel  = reg_wr && (reg_addr == A_SEL);
   wire wr_cyc  = reg_wr && (reg_addr == A_CYC);
   wire wr_val  = reg_wr && (reg_addr == A_VAL);
   wire wr_type = reg_wr && (reg_addr == A_TYPE);

   assign evt_rst = wr_ctrl && reg_wdata[1];
   assign cyc_rst = wr_ctrl && reg_wdata[2];
   assign sel_ok  = (32'(sel_q) < 32'(NUM_CTR));
   assign cyc_run = ctrl_en_q && en_q[CYC_BIT] && !(ctrl_dbg_q && dbg_inhibit);

   // control, enables, selector
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en_q  <= 1'b0;
         ctrl_div_q <= 1'b0;
         ctrl_exp_q <= 1'b0;
         ctrl_dbg_q <= 1'b0;
         en_q       <= '0;
         ie_q       <= '0;
         ovf_q      <= '0;
         sel_q      <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_en_q  <= reg_wdata[0];
            ctrl_div_q <= reg_wdata[3];
            ctrl_exp_q <= reg_wdata[4];
            ctrl_dbg_q <= reg_wdata[5];
         end
         if (wr_enst)      en_q <= (en_q | reg_wdata) & IMPL_MASK;
         else if (wr_encl) en_q <= en_q & ~reg_wdata;
         if (wr_iest)      ie_q <= (ie_q | reg_wdata) & IMPL_MASK;
         else if (wr_iecl) ie_q <= ie_q & ~reg_wdata;
         // a wrap on the same edge as a clear leaves the flag set
         ovf_q <= ((ovf_q & ~(wr_ovf ? reg_wdata : 32'h0)) | wrap_v) & IMPL_MASK;
         if (wr_sel) sel_q <= reg_wdata[SEL_W-1:0];
      end
   end

   // cycle counter
   pmu_prescaler #(.DIV_LOG2(DIV_LOG2), .HAS_DIV(HAS_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(cyc_rst), .active(cyc_run),
      .div_mode(ctrl_div_q), .tick(cyc_tick)
   );

   pmu_counter #(.W(CNT_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clr(cyc_rst), .ld(wr_cyc),
      .ld_val(reg_wdata[CNT_W-1:0]), .inc(cyc_tick),
      .cnt(cyc_cnt), .wrap(wrap_v[CYC_BIT])
   );

   // event counter bank
   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic              hit, picked;
      logic [CODE_W-1:0] type_q;

      assign picked = sel_ok && (sel_q == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 type_q <= '0;
         else if (wr_type && picked) type_q <= reg_wdata[CODE_W-1:0];
      end
      assign evt_type[i] = type_q;

      pmu_evt_mux #(.NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_mux (
         .code(type_q), .evt_in(evt_in), .hit(hit)
      );

      pmu_counter #(.W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(evt_rst), .ld(wr_val && picked),
         .ld_val(reg_wdata[CNT_W-1:0]), .inc(ctrl_en_q && en_q[i] && hit),
         .cnt(evt_cnt[i]), .wrap(wrap_v[i])
      );
   end
   for (genvar k = NUM_CTR; k < CYC_BIT; k++) begin : g_nowrap
      assign wrap_v[k] = 1'b0;
   end

   // read path
   logic [CNT_W-1:0]  win_val;
   logic [CODE_W-1:0] win_type;
   always_comb begin
      win_val  = '0;
      win_type = '0;
      for (int i = 0; i < NUM_CTR; i++)
         if (sel_q == SEL_W'(i)) begin
            win_val  = evt_cnt[i];
            win_type = evt_type[i];
         end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:             reg_rdata = (32'(NUM_CTR) << NUMF_LSB) |
                                         {26'h0, ctrl_dbg_q, ctrl_exp_q, ctrl_div_q, 2'b00, ctrl_en_q};
         A_EN_SET, A_EN_CLR: reg_rdata = en_q;
         A_IE_SET, A_IE_CLR: reg_rdata = ie_q;
         A_OVF:              reg_rdata = ovf_q;
         A_SEL:              reg_rdata = 32'(sel_q);
         A_CYC:              reg_rdata = 32'(cyc_cnt);
         A_VAL:              reg_rdata = 32'(win_val);
         A_TYPE:             reg_rdata = 32'(win_type);
         default:            reg_rdata = 32'h0;
      endcase
   end

   assign irq       = |(ovf_q & ie_q);
   assign export_en = ctrl_exp_q;
endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
   import pmu_pkg::*;
#(
   parameter int          CNT_W     = 32,
   parameter bit          HAS_DIV   = 1'b1,
   parameter logic [31:0] IMPL_MASK = 32'h8000_000F
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [3:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic             ctrl_en_q,
   input logic             ctrl_div_q,
   input logic [31:0]      en_q,
   input logic [31:0]      ie_q,
   input logic [31:0]      ovf_q,
   input logic [CNT_W-1:0] cyc_cnt,
   input logic             cyc_tick,
   input logic             cyc_rst,
   input logic             irq
);
   wire wr_cyc  = reg_wr && (reg_addr == A_CYC);
   wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);

   // R3: global enable off holds the cycle counter
   assert_cyc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en_q && !wr_cyc && !cyc_rst) |=> $stable(cyc_cnt));

   // R4: set register turns on every requested implemented bit
   assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_EN_SET) |=>
      ((en_q & $past(reg_wdata) & IMPL_MASK) == ($past(reg_wdata) & IMPL_MASK)));

   // R4: clear register turns off every requested bit
   assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_EN_CLR) |=> ((en_q & $past(reg_wdata)) == 32'h0));

   // R9: divided mode never steps on two edges in a row
   assert_div_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_DIV && ctrl_div_q && cyc_tick && !wr_ctrl) |=> !cyc_tick);

   // R11: cycle counter wrap raises its flag
   assert_cyc_wrap_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_tick && (&cyc_cnt) && !wr_cyc && !cyc_rst) |=> ovf_q[CYC_BIT]);

   // R12: no interrupt without an interrupt enable
   assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q == 32'h0) |-> !irq);
endmodule

bind perf_mon_unit pmu_chk #(.CNT_W(CNT_W), .HAS_DIV(HAS_DIV), .IMPL_MASK(IMPL_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .ctrl_en_q(ctrl_en_q), .ctrl_div_q(ctrl_div_q), .en_q(en_q), .ie_q(ie_q), .ovf_q(ovf_q),
   .cyc_cnt(cyc_cnt), .cyc_tick(cyc_tick), .cyc_rst(cyc_rst), .irq(irq)
);

// File: tb/tb_perf_mon_unit.sv
`timescale 1ns/1ps
module tb_perf_mon_unit;
   localparam int NC = 4;
   localparam int NE = 8;
   localparam logic [3:0] CTRL = 4'h0, ENS = 4'h1, ENC = 4'h2, IES = 4'h3, IEC = 4'h4,
                          OVF = 4'h5, SEL = 4'h6, CYC = 4'h7, VAL = 4'h8, TYP = 4'h9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NE-1:0] evt_in = '0;
   logic          dbg_inhibit = 1'b0;
   logic          irq, export_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   perf_mon_unit #(.NUM_CTR(NC), .NUM_EVT(NE)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
      .dbg_inhibit(dbg_inhibit), .irq(irq), .export_en(export_en)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at a falling edge, commit at the next rising edge
   task automatic wr(logic [3:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // sample just after a falling edge, then move on one cycle
   task automatic rd(logic [3:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
      @(negedge clk);
   endtask

   function automatic bit evt_hit(int code, logic [NE-1:0] e);
      if (code < NE) return e[code];
      return 1'b0;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int codes [NC];
      int expc [NC];
      int expcyc;
      logic [31:0] mask;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(CTRL, v); chk("R1 ctrl", v, 32'h0000_2000);
      rd(CYC, v);  chk("R1 cyc", v, 32'h0);
      rd(OVF, v);  chk("R1 ovf", v, 32'h0);
      rd(ENS, v);  chk("R1 en", v, 32'h0);
      rd(IES, v);  chk("R1 ie", v, 32'h0);
      rd(VAL, v);  chk("R1 val0", v, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);

      // random rounds (R3 R5)
      for (int r = 0; r < 20; r++) begin
         mask = 32'($urandom_range(0, 15)) | (32'($urandom_range(0, 1)) << 31);
         wr(CTRL, 32'h0);
         wr(ENC, 32'hFFFF_FFFF);
         for (int i = 0; i < NC; i++) begin
            codes[i] = $urandom_range(0, NE + 3);
            wr(SEL, i);
            wr(TYP, 32'(codes[i]));
            expc[i] = 0;
         end
         wr(ENS, mask);
         wr(CTRL, 32'h7);
         expcyc = 0;
         for (int c = 0; c < int'($urandom_range(5, 40)); c++) begin
            evt_in = NE'($urandom);
            for (int i = 0; i < NC; i++)
               if (mask[i] && evt_hit(codes[i], evt_in)) expc[i]++;
            if (mask[31]) expcyc++;
            @(negedge clk);
         end
         evt_in = '0;
         wr(CTRL, 32'h0);
         if (mask[31]) expcyc++;
         rd(CYC, v); chk("R3 random cycle count", v, 32'(expcyc));
         for (int i = 0; i < NC; i++) begin
            wr(SEL, i);
            rd(VAL, v); chk("R5 random event count", v, 32'(expc[i]));
         end
      end

      // R5 code width and out-of-range codes
      wr(CTRL, 32'h6);
      wr(ENC, 32'hFFFF_FFFF);
      wr(SEL, 0);
      wr(TYP, 32'h1FF);
      rd(TYP, v); chk("R5 code keeps 8 bits", v, 32'hFF);
      wr(ENS, 32'h1);
      wr(CTRL, 32'h3);
      evt_in = '1;
      repeat (10) @(negedge clk);
      evt_in = '0;
      wr(CTRL, 32'h0);
      rd(VAL, v); chk("R5 out-of-range code counts nothing", v, 32'h0);
      wr(TYP, 32'h3);
      wr(CTRL, 32'h3);
      evt_in = 8'h08;
      repeat (10) @(negedge clk);
      evt_in = '0;
      wr(CTRL, 32'h0);
      rd(VAL, v); chk("R5 line 3 counted", v, 32'd10);

      // R6 selector beyond the bank
      wr(SEL, 4);
      rd(VAL, v); chk("R6 empty value window", v, 32'h0);
      rd(TYP, v); chk("R6 empty code window", v, 32'h0);
      wr(VAL, 32'h1234);
      wr(TYP, 32'h5);
      wr(SEL, 0);
      rd(VAL, v); chk("R6 value write ignored", v, 32'd10);
      rd(TYP, v); chk("R6 code write ignored", v, 32'h3);
      wr(SEL, 32'h3F);
      rd(SEL, v); chk("R6 selector 5 bits", v, 32'h1F);

      // R2 R8 R13 control behaviour
      wr(CTRL, 32'h10);
      chk("R13 export", 32'(export_en), 32'h1);
      rd(CTRL, v); chk("R2 ctrl readback", v, 32'h0000_2010);
      wr(CYC, 32'd100);
      wr(SEL, 0);
      wr(VAL, 32'd55);
      wr(CTRL, 32'h2);
      rd(VAL, v); chk("R8 event reset", v, 32'h0);
      rd(CYC, v); chk("R8 cycle kept", v, 32'd100);
      wr(VAL, 32'd55);
      wr(CTRL, 32'h4);
      rd(CYC, v); chk("R8 cycle reset", v, 32'h0);
      rd(VAL, v); chk("R8 event kept", v, 32'd55);
      wr(CTRL, 32'hFFFF_FFFF);
      rd(CTRL, v); chk("R2 writable bits only", v, 32'h0000_2039);
      wr(CTRL, 32'h0);
      chk("R13 export off", 32'(export_en), 32'h0);

      // R7 R11 R12 cycle counter wrap
      wr(ENC, 32'hFFFF_FFFF);
      wr(ENS, 32'h8000_0000);
      wr(IES, 32'h8000_0000);
      wr(OVF, 32'hFFFF_FFFF);
      wr(CTRL, 32'h1);
      wr(CYC, 32'hFFFF_FFFF);
      rd(CYC, v); chk("R7 write beats increment", v, 32'hFFFF_FFFF);
      rd(OVF, v); chk("R11 cycle flag", v, 32'h8000_0000);
      chk("R12 irq on", 32'(irq), 32'h1);
      rd(CYC, v); chk("R11 wrapped and continued", v, 32'h1);
      wr(CTRL, 32'h0);
      wr(IEC, 32'h8000_0000);
      chk("R12 irq masked", 32'(irq), 32'h0);
      rd(IES, v); chk("R4 ie clear", v, 32'h0);
      wr(IES, 32'h8000_0000);
      chk("R12 irq back", 32'(irq), 32'h1);
      wr(OVF, 32'h0000_0001);
      rd(OVF, v); chk("R11 zero bits keep flag", v, 32'h8000_0000);
      wr(OVF, 32'h8000_0000);
      rd(OVF, v); chk("R11 flag cleared", v, 32'h0);
      chk("R12 irq off", 32'(irq), 32'h0);

      // R11 R12 event counter wrap
      wr(ENC, 32'hFFFF_FFFF);
      wr(ENS, 32'h2);
      rd(ENS, v); chk("R4 set leaves others", v, 32'h2);
      wr(SEL, 1);
      wr(TYP, 32'h0);
      wr(VAL, 32'hFFFF_FFFE);
      wr(CTRL, 32'h1);
      evt_in = 8'h01;
      repeat (2) @(negedge clk);
      evt_in = '0;
      wr(CTRL, 32'h0);
      rd(OVF, v); chk("R11 event flag", v, 32'h2);
      rd(VAL, v); chk("R11 event wrapped", v, 32'h0);
      chk("R12 no irq without enable", 32'(irq), 32'h0);
      wr(IES, 32'h2);
      chk("R12 irq event", 32'(irq), 32'h1);
      wr(OVF, 32'h2);
      wr(IEC, 32'hFFFF_FFFF);

      // R9 divide by 64
      wr(ENS, 32'h8000_0000);
      wr(CTRL, 32'hD);
      repeat (63) @(negedge clk);
      rd(CYC, v); chk("R9 no step before 64", v, 32'h0);
      rd(CYC, v); chk("R9 step at 64", v, 32'h1);
      wr(CTRL, 32'h0);

      // R10 debug inhibit
      wr(SEL, 0);
      wr(TYP, 32'h1);
      wr(ENS, 32'h1);
      dbg_inhibit = 1'b1;
      wr(CTRL, 32'h27);
      evt_in = 8'h02;
      repeat (10) @(negedge clk);
      evt_in = '0;
      wr(CTRL, 32'h20);
      rd(CYC, v); chk("R10 cycle held", v, 32'h0);
      rd(VAL, v); chk("R10 events unaffected", v, 32'd10);
      wr(CTRL, 32'h5);
      repeat (10) @(negedge clk);
      wr(CTRL, 32'h0);
      rd(CYC, v); chk("R10 runs without stop bit", v, 32'd11);
      dbg_inhibit = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule